// File: doc/BRIEF.md
# Real-Time-Clock Register Access Snooper

This block sits beside an I2C bus decoder and watches the stream of bus events it produces, one event per cycle at most. It follows the transactions aimed at a real-time-clock slave and keeps a shadow copy of the time and date fields the clock holds. Each event has a kind (start, repeated start, address write, address read, data write, data read, stop) and a byte. For address events the byte is the full 8-bit address; for data events it is the data byte.

A write transfer names a register index with its first data byte. After that, each data byte lands in the register at the current index, and the index then steps by one. A repeated start followed by an address read switches the transfer to the read path, where the bytes the slave returns are captured the same way. Time and date registers hold BCD values. The block masks off the bits that are not part of each field and converts the rest to binary.

A stop that ends a write or a read produces a one-cycle summary pulse. The pulse comes with a direction bit and a snapshot of the six binary fields. The snapshot holds until the next summary. The voltage-low flag and the five interrupt control bits are also kept visible.

Top module: `rtc_bus_snoop`

## Requirements
- R1: While reset is held and right after it, `sum_valid` is 0 and every other output is 0.
- R2: Event kinds are coded as 0 start, 1 repeated start, 2 address write, 3 address read, 4 data write, 5 data read, 6 stop. A transfer of the form start, address write, data write (index), data writes, stop gives exactly one `sum_valid` pulse with `sum_is_read`=0. The pulse appears in the cycle after the stop event is accepted.
- R3: The first data write after the address loads the register index. Each later data byte in the data phase goes to the current index, and the index then increments by one, wrapping from 0xFF to 0x00.
- R4: A field byte is masked and then converted as low nibble + 10 × high nibble. The fields and masks are: index 0x02 seconds (0x7F), 0x03 minutes (0x7F), 0x04 hours (0x3F), 0x05 days (0x3F), 0x07 months (0x1F), 0x08 years (0xFF).
- R5: `volt_low` follows bit 7 of the last byte captured at index 0x02.
- R6: `ctrl_flags[4:0]` takes bits 4:0 of the last byte captured at index 0x01. The bits are, from 4 down to 0: repeat-timer mode, alarm flag, timer flag, alarm interrupt enable, timer interrupt enable.
- R7: A repeated start in the write-data phase, then an address read, starts the read-data phase. There each data-read byte is captured and the index incremented. A stop there gives one pulse with `sum_is_read`=1.
- R8: With `filter_en`=1, only address 0xA2 is accepted as an address write and only 0xA3 as an address read. Any other address is ignored, and the block keeps waiting for an address. With `filter_en`=0, any address is accepted.
- R9: An event not expected in the current state is ignored: the state does not change, no field changes and no summary is produced. This includes a data read in the write phase, a data write in the read phase, and any event in idle other than start.
- R10: `field_seen` bit order is 0 seconds, 1 minutes, 2 hours, 3 days, 4 months, 5 years. A bit is set when its field is captured and is cleared only by reset.
- R11: Capture at index 0x00, 0x06, 0x09 to 0x0F, or any index above 0x0F changes no output.
- R12: `sum_valid` is high for one cycle per ending stop. The `sum_*` fields and `sum_is_read` stay unchanged between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| filter_en | input | 1 | Accept only the clock's slave addresses |
| ev_valid | input | 1 | An event is presented this cycle |
| ev_kind | input | 3 | Event kind code |
| ev_data | input | 8 | Address or data byte of the event |
| sum_valid | output | 1 | One-cycle summary pulse |
| sum_is_read | output | 1 | Summary belongs to a read transfer |
| sum_sec | output | 8 | Seconds, binary |
| sum_min | output | 8 | Minutes, binary |
| sum_hour | output | 8 | Hours, binary |
| sum_day | output | 8 | Days, binary |
| sum_month | output | 8 | Months, binary |
| sum_year | output | 8 | Years, binary |
| field_seen | output | 6 | Per-field captured flags |
| volt_low | output | 1 | Voltage-low flag |
| ctrl_flags | output | 5 | Interrupt control bits |

## Verification
A wrong sequencer state shows up at a stop. The summary either goes missing, is duplicated, or carries the wrong direction, and a scoreboard comparison catches this in the cycle after the stop. A drifting register index does not show until the next summary, when fields come out shifted by one register. It can also show sooner through `field_seen`, `volt_low` or `ctrl_flags`, which change one cycle after the misrouted byte. Filtered addresses and ignored events are checked by sending stops and data afterwards and confirming that no pulse and no flag change follows.

// File: rtl/rtc_snoop_pkg.sv
package rtc_snoop_pkg;

  localparam int BYTE_W     = 8;
  localparam int NUM_FIELDS = 6;
  localparam int CTL_BITS   = 5;

  localparam logic [BYTE_W-1:0] IDX_CTL2 = 8'h01;
  localparam logic [BYTE_W-1:0] IDX_SEC  = 8'h02;

  typedef enum logic [2:0] {
    EV_START   = 3'd0,
    EV_RESTART = 3'd1,
    EV_ADDR_WR = 3'd2,
    EV_ADDR_RD = 3'd3,
    EV_DATA_WR = 3'd4,
    EV_DATA_RD = 3'd5,
    EV_STOP    = 3'd6
  } ev_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WADDR,
    ST_WIDX,
    ST_WDATA,
    ST_RADDR,
    ST_RDATA
  } snoop_state_e;

  // register index of field slot i (0 sec .. 5 year)
  function automatic logic [BYTE_W-1:0] field_idx(input int i);
    case (i)
      0:       return 8'h02;
      1:       return 8'h03;
      2:       return 8'h04;
      3:       return 8'h05;
      4:       return 8'h07;
      default: return 8'h08;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] field_mask(input int i);
    case (i)
      0, 1:    return 8'h7F;
      2, 3:    return 8'h3F;
      4:       return 8'h1F;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] bcd_to_bin(input logic [BYTE_W-1:0] b);
    return BYTE_W'(b[7:4]) * 8'd10 + BYTE_W'(b[3:0]);
  endfunction

endpackage

// File: rtl/snoop_rst_sync.sv
module snoop_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sh_q[STAGES-1];
endmodule

// File: rtl/snoop_seq.sv
module snoop_seq
  import rtc_snoop_pkg::*;
#(
  parameter logic [BYTE_W-1:0] WR_ADDR = 8'hA2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              filter_en,
  input  logic              ev_valid,
  input  logic [2:0]        ev_kind,
  input  logic [BYTE_W-1:0] ev_data,
  output logic              cap_en,
  output logic [BYTE_W-1:0] cap_idx,
  output logic [BYTE_W-1:0] cap_data,
  output logic              done,
  output logic              done_read
);
  localparam logic [BYTE_W-1:0] RD_ADDR = WR_ADDR | 8'h01;

  snoop_state_e      st_q, st_d;
  logic [BYTE_W-1:0] ptr_q, ptr_d;
  logic              ptr_en;
  logic              wr_ok, rd_ok;
  ev_kind_e          kind;

  always_comb begin
    kind      = ev_kind_e'(ev_kind);
    wr_ok     = !filter_en || (ev_data == WR_ADDR);
    rd_ok     = !filter_en || (ev_data == RD_ADDR);
    st_d      = st_q;
    ptr_d     = ptr_q + 1'b1;
    ptr_en    = 1'b0;
    cap_en    = 1'b0;
    done      = 1'b0;
    done_read = 1'b0;
    if (ev_valid) begin
      unique case (st_q)
        ST_IDLE:  if (kind == EV_START) st_d = ST_WADDR;
        ST_WADDR: if (kind == EV_ADDR_WR && wr_ok) st_d = ST_WIDX;
        ST_WIDX: begin
          if (kind == EV_DATA_WR) begin
            st_d   = ST_WDATA;
            ptr_en = 1'b1;
            ptr_d  = ev_data;
          end
        end
        ST_WDATA: begin
          if (kind == EV_DATA_WR) begin
            cap_en = 1'b1;
            ptr_en = 1'b1;
          end else if (kind == EV_RESTART) begin
            st_d = ST_RADDR;
          end else if (kind == EV_STOP) begin
            done = 1'b1;
            st_d = ST_IDLE;
          end
        end
        ST_RADDR: if (kind == EV_ADDR_RD && rd_ok) st_d = ST_RDATA;
        ST_RDATA: begin
          if (kind == EV_DATA_RD) begin
            cap_en = 1'b1;
            ptr_en = 1'b1;
          end else if (kind == EV_STOP) begin
            done      = 1'b1;
            done_read = 1'b1;
            st_d      = ST_IDLE;
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  assign cap_idx  = ptr_q;
  assign cap_data = ev_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end
endmodule

// File: rtl/snoop_field_bank.sv
module snoop_field_bank
  import rtc_snoop_pkg::*;
(
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               cap_en,
  input  logic [BYTE_W-1:0]                  cap_idx,
  input  logic [BYTE_W-1:0]                  cap_data,
  output logic [NUM_FIELDS-1:0][BYTE_W-1:0]  fld,
  output logic [NUM_FIELDS-1:0]              seen,
  output logic                               volt_low,
  output logic [CTL_BITS-1:0]                ctrl_flags
);
  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_fld
    localparam logic [BYTE_W-1:0] IDX  = field_idx(g);
    localparam logic [BYTE_W-1:0] MASK = field_mask(g);
    logic              hit;
    logic [BYTE_W-1:0] val_d, val_q;
    logic              seen_q;

    assign hit   = cap_en && (cap_idx == IDX);
    assign val_d = bcd_to_bin(cap_data & MASK);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        val_q  <= '0;
        seen_q <= 1'b0;
      end else if (hit) begin
        val_q  <= val_d;
        seen_q <= 1'b1;
      end
    end

    assign fld[g]  = val_q;
    assign seen[g] = seen_q;
  end

  logic vl_hit, ctl_hit;
  assign vl_hit  = cap_en && (cap_idx == IDX_SEC);
  assign ctl_hit = cap_en && (cap_idx == IDX_CTL2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      volt_low <= 1'b0;
    else if (vl_hit) volt_low <= cap_data[BYTE_W-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ctrl_flags <= '0;
    else if (ctl_hit) ctrl_flags <= cap_data[CTL_BITS-1:0];
  end
endmodule

// File: rtl/rtc_bus_snoop.sv
module rtc_bus_snoop
  import rtc_snoop_pkg::*;
#(
  parameter logic [7:0] SLAVE_WR_ADDR = 8'hA2,
  parameter int         SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       filter_en,
  input  logic       ev_valid,
  input  logic [2:0] ev_kind,
  input  logic [7:0] ev_data,
  output logic       sum_valid,
  output logic       sum_is_read,
  output logic [7:0] sum_sec,
  output logic [7:0] sum_min,
  output logic [7:0] sum_hour,
  output logic [7:0] sum_day,
  output logic [7:0] sum_month,
  output logic [7:0] sum_year,
  output logic [5:0] field_seen,
  output logic       volt_low,
  output logic [4:0] ctrl_flags
);
  logic                              rst_i;
  logic                              cap_en, done, done_read;
  logic [BYTE_W-1:0]                 cap_idx, cap_data;
  logic [NUM_FIELDS-1:0][BYTE_W-1:0] fld;

  snoop_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_i)
  );

  snoop_seq #(.WR_ADDR(SLAVE_WR_ADDR)) u_seq (
    .clk(clk), .rst_n(rst_i), .filter_en(filter_en),
    .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_data(ev_data),
    .cap_en(cap_en), .cap_idx(cap_idx), .cap_data(cap_data),
    .done(done), .done_read(done_read)
  );

  snoop_field_bank u_bank (
    .clk(clk), .rst_n(rst_i), .cap_en(cap_en), .cap_idx(cap_idx),
    .cap_data(cap_data), .fld(fld), .seen(field_seen),
    .volt_low(volt_low), .ctrl_flags(ctrl_flags)
  );

  // summary snapshot: pulse plus fields held until the next stop
  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) sum_valid <= 1'b0;
    else        sum_valid <= done;
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sum_is_read <= 1'b0;
      sum_sec     <= '0;
      sum_min     <= '0;
      sum_hour    <= '0;
      sum_day     <= '0;
      sum_month   <= '0;
      sum_year    <= '0;
    end else if (done) begin
      sum_is_read <= done_read;
      sum_sec     <= fld[0];
      sum_min     <= fld[1];
      sum_hour    <= fld[2];
      sum_day     <= fld[3];
      sum_month   <= fld[4];
      sum_year    <= fld[5];
    end
  end
endmodule

// File: rtl/rtc_bus_snoop_chk.sv
module rtc_bus_snoop_chk
  import rtc_snoop_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       filter_en,
  input logic       ev_valid,
  input logic [2:0] ev_kind,
  input logic [7:0] ev_data,
  input logic       sum_valid,
  input logic       sum_is_read,
  input logic [7:0] sum_sec,
  input logic [7:0] sum_min,
  input logic [7:0] sum_hour,
  input logic [7:0] sum_day,
  input logic [7:0] sum_month,
  input logic [7:0] sum_year,
  input logic [5:0] field_seen,
  input logic       volt_low,
  input logic [4:0] ctrl_flags
);
  // a summary only follows an accepted stop event
  p_pulse_after_stop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |-> ($past(ev_valid) && $past(ev_kind) == EV_STOP));

  p_single_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sum_valid |=> !sum_valid);

  p_hold_fields_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !sum_valid |-> ($stable(sum_sec) && $stable(sum_min) && $stable(sum_hour) &&
                    $stable(sum_day) && $stable(sum_month) && $stable(sum_year) &&
                    $stable(sum_is_read)));

  p_seen_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(field_seen) & ~field_seen) == 6'b0));

  // masked BCD bounds the binary result
  p_masked_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sum_sec <= 8'd85 && sum_min <= 8'd85 && sum_hour <= 8'd45 &&
     sum_day <= 8'd45 && sum_month <= 8'd25));

  p_flags_need_data_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_flags != $past(ctrl_flags)) |->
      ($past(ev_valid) && ($past(ev_kind) == EV_DATA_WR || $past(ev_kind) == EV_DATA_RD)));

  p_vl_needs_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (volt_low != $past(volt_low)) |->
      ($past(ev_valid) && ($past(ev_kind) == EV_DATA_WR || $past(ev_kind) == EV_DATA_RD)));
endmodule

bind rtc_bus_snoop rtc_bus_snoop_chk u_chk (.*);

// File: tb/tb_rtc_bus_snoop.sv
module tb_rtc_bus_snoop;
  localparam logic [2:0] K_START = 3'd0, K_RESTART = 3'd1, K_AW = 3'd2, K_AR = 3'd3,
                         K_DW = 3'd4, K_DR = 3'd5, K_STOP = 3'd6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       filter_en = 1'b1;
  logic       ev_valid = 1'b0;
  logic [2:0] ev_kind = 3'd0;
  logic [7:0] ev_data = 8'd0;
  logic       sum_valid, sum_is_read, volt_low;
  logic [7:0] sum_sec, sum_min, sum_hour, sum_day, sum_month, sum_year;
  logic [5:0] field_seen;
  logic [4:0] ctrl_flags;

  rtc_bus_snoop dut (.*);

  always #2 clk = ~clk;

  typedef struct packed {
    logic rd; logic [7:0] s; logic [7:0] m; logic [7:0] h;
    logic [7:0] d; logic [7:0] mo; logic [7:0] y;
  } sum_t;

  int   n_chk = 0, n_bad = 0;
  bit   finished = 0;
  sum_t expq[$];
  logic [7:0] mf [6];
  logic [5:0] m_seen = '0;
  logic       m_vl = 1'b0;
  logic [4:0] m_ctl = '0;
  logic [7:0] mptr = '0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] b2i(input logic [7:0] b);
    return 8'(b[3:0]) + 8'(b[7:4]) * 8'd10;
  endfunction

  task automatic model_cap(input logic [7:0] idx, input logic [7:0] b);
    case (idx)
      8'h01: m_ctl = b[4:0];
      8'h02: begin mf[0] = b2i(b & 8'h7F); m_seen[0] = 1'b1; m_vl = b[7]; end
      8'h03: begin mf[1] = b2i(b & 8'h7F); m_seen[1] = 1'b1; end
      8'h04: begin mf[2] = b2i(b & 8'h3F); m_seen[2] = 1'b1; end
      8'h05: begin mf[3] = b2i(b & 8'h3F); m_seen[3] = 1'b1; end
      8'h07: begin mf[4] = b2i(b & 8'h1F); m_seen[4] = 1'b1; end
      8'h08: begin mf[5] = b2i(b); m_seen[5] = 1'b1; end
      default: ;
    endcase
  endtask

  task automatic ev(input logic [2:0] k, input logic [7:0] b);
    @(negedge clk);
    ev_valid = 1'b1; ev_kind = k; ev_data = b;
    @(negedge clk);
    ev_valid = 1'b0;
  endtask

  task automatic set_idx(input logic [7:0] b);
    ev(K_DW, b); mptr = b;
  endtask

  task automatic wd(input logic [7:0] b);
    ev(K_DW, b); model_cap(mptr, b); mptr = mptr + 8'd1;
  endtask

  task automatic rdb(input logic [7:0] b);
    ev(K_DR, b); model_cap(mptr, b); mptr = mptr + 8'd1;
  endtask

  task automatic stop_exp(input logic rd);
    expq.push_back({rd, mf[0], mf[1], mf[2], mf[3], mf[4], mf[5]});
    ev(K_STOP, 8'h00);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && sum_valid) begin
      sum_t a, e;
      a = {sum_is_read, sum_sec, sum_min, sum_hour, sum_day, sum_month, sum_year};
      n_chk++;
      if (expq.size() == 0) begin
        n_bad++;
        $display("FAIL R12 unexpected summary actual=%0h expected=none", a);
      end else begin
        e = expq.pop_front();
        if (a !== e) begin
          n_bad++;
          $display("FAIL R2/R7 summary actual=%0h expected=%0h", a, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) mf[i] = 8'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 sum_valid", 64'(sum_valid), 64'd0);
    check("R1 fields", 64'({sum_sec, sum_min, sum_hour, sum_day, sum_month, sum_year}), 64'd0);
    check("R1 flags", 64'({field_seen, volt_low, ctrl_flags}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 after release", 64'({sum_valid, field_seen, volt_low, ctrl_flags}), 64'd0);

    // R9 events in idle ignored
    ev(K_DW, 8'h02); ev(K_DW, 8'h55); ev(K_STOP, 8'h00); ev(K_AW, 8'hA2);
    check("R9 idle ignored seen", 64'(field_seen), 64'd0);

    // R2 R3 R4 R5 R6 R10 full write from index 1
    ev(K_START, 8'h00); ev(K_AW, 8'hA2); set_idx(8'h01);
    wd(8'h1B); wd(8'hD9); wd(8'h47); wd(8'hE3); wd(8'h31); wd(8'h05); wd(8'h92); wd(8'h99);
    check("R6 ctrl_flags", 64'(ctrl_flags), 64'h1B);
    check("R5 volt_low set", 64'(volt_low), 64'd1);
    check("R10 all seen", 64'(field_seen), 64'h3F);
    stop_exp(1'b0);
    repeat (2) @(negedge clk);
    check("R4 hours masked", 64'(sum_hour), 64'd23);
    check("R4 months masked", 64'(sum_month), 64'd12);
    check("R4 seconds masked", 64'(sum_sec), 64'd59);

    // R7 read path, R9 data write in read phase ignored
    ev(K_START, 8'h00); ev(K_AW, 8'hA2); set_idx(8'h02);
    ev(K_RESTART, 8'h00); ev(K_AR, 8'hA3);
    rdb(8'h12); rdb(8'h05);
    ev(K_DW, 8'h11);
    check("R5 volt_low cleared", 64'(volt_low), 64'd0);
    stop_exp(1'b1);
    repeat (2) @(negedge clk);
    check("R9 hours kept", 64'(sum_hour), 64'd23);

    // R8 write address filter
    ev(K_START, 8'h00); ev(K_AW, 8'hD0); ev(K_DW, 8'h03); ev(K_DW, 8'h11); ev(K_STOP, 8'h00);
    check("R8 bad write addr no capture", 64'(sum_min), 64'd5);
    ev(K_AW, 8'hA2); set_idx(8'h03); wd(8'h33);
    ev(K_DR, 8'h44);  // R9 data read in write phase ignored
    stop_exp(1'b0);
    // R8 read address filter
    ev(K_START, 8'h00); ev(K_AW, 8'hA2); set_idx(8'h05);
    ev(K_RESTART, 8'h00); ev(K_AR, 8'hA5); ev(K_DR, 8'h22); ev(K_AR, 8'hA3);
    rdb(8'h28);
    stop_exp(1'b1);
    repeat (2) @(negedge clk);
    check("R8 day from filtered read", 64'(sum_day), 64'd28);

    // R8 filter disabled
    filter_en = 1'b0;
    ev(K_START, 8'h00); ev(K_AW, 8'h40); set_idx(8'h08); wd(8'h07);
    stop_exp(1'b0);
    filter_en = 1'b1;

    // R11 out-of-range indices, R3 wrap to index 1
    ev(K_START, 8'h00); ev(K_AW, 8'hA2); set_idx(8'h0E);
    wd(8'h44); wd(8'h44); wd(8'h44);
    check("R11 no flag change", 64'({volt_low, ctrl_flags}), 64'h1B);
    stop_exp(1'b0);
    ev(K_START, 8'h00); ev(K_AW, 8'hA2); set_idx(8'hFF);
    wd(8'h10); wd(8'h00); wd(8'h04);
    check("R3 wrap reaches index 1", 64'(ctrl_flags), 64'h04);
    stop_exp(1'b0);

    // R12 hold between pulses
    repeat (6) @(negedge clk);
    check("R12 year held", 64'(sum_year), 64'd7);
    check("R12 minutes held", 64'(sum_min), 64'd33);
    check("R10 seen model", 64'(field_seen), 64'(m_seen));
    check("R12 all summaries seen", 64'(expq.size()), 64'd0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule